// File: doc/BRIEF.md
# Four-Channel Converter SPI Register Bank

This block is the serial control port of a four-channel converter controller. A host sends 24-bit frames over an SPI-style link (chip select, serial clock, data in, data out). Each frame carries a read flag, a two-bit device address compared against strap pins, a five-bit register selector and a 16-bit payload. Write frames load the per-channel code, control, gain, offset, clear-code and slew-control registers, and the two global control words. Every register is also driven onto parallel output ports for the converter logic.

Readback is pipelined by one frame. A read frame only names a register. Its contents are shifted out on the data output while the host sends the next frame, which should be another read or the no-operation word 0x1CE000. The SPI pins are oversampled by the system clock through a configurable synchronizer. A frame is acted on only when chip select rises after exactly 24 serial clock edges.

Top module: `chan_spi_regfile`

## Requirements
- R1: A frame is 24 bits, most significant bit first. Bit 23 set means read. Bits 22:21 hold the device address and bits 20:16 the selector. Bits 15:0 are the write payload and are ignored on reads.
- R2: A frame takes effect on the rising edge of chip select only if exactly 24 rising serial clock edges were seen while chip select was low. A shorter or longer frame changes no register and leaves any pending readback armed.
- R3: Write selectors map as follows: 0–3 channel A–D code, 4–7 control, 8–11 gain, 12–15 offset, 16–19 clear code, 20–23 slew control, 25 main control, 26 dc-to-dc control. Selector 24 and selectors 27–31 write nothing.
- R4: A read frame with a matching address arms readback of its selector. During the next frame the output carries 24 bits: bits 23:16 are zero and bits 15:0 hold the register, MSB first. Reads use the same selector map as writes. Selector 24 returns the status input, and selectors 27–31 return zero.
- R5: Any completed frame other than a matching read disarms readback, so the frame after it shifts out zeros. This covers writes, the no-operation word 0x1CE000 and frames for another device. The no-operation word changes no register but still carries out data that is already pending.
- R6: A completed frame whose address differs from the strap pins writes no register and arms no read.
- R7: A slew-control register keeps only bits 12:3: the enable in bit 12, the clock-rate code in bits 11:7 and the step code in bits 6:3. All other bits read and output as zero.
- R8: Reset clears every register and the pending readback. The first frame after reset shifts out zeros.
- R9: The first output bit is valid after chip select falls. The output advances after each falling serial clock edge and is meant to be sampled on the rising edge. While chip select is high the output sits at the idle level (0 by default).
- R10: Each per-channel output port places channel c in bits 16c+15:16c. The main and dc-to-dc control words have ports of their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial readback data to host |
| dev_addr | input | 2 | Strapped device address |
| status_word | input | 16 | Status value returned by selector 24 |
| ch_code | output | 64 | Converter code registers, four channels |
| ch_ctrl | output | 64 | Channel control registers |
| ch_gain | output | 64 | Channel gain registers |
| ch_offset | output | 64 | Channel offset registers |
| ch_clear | output | 64 | Channel clear-code registers |
| ch_slew | output | 64 | Channel slew-control registers (bits 12:3 live) |
| main_ctrl | output | 16 | Main control register |
| dcdc_ctrl | output | 16 | Dc-to-dc control register |

## Verification
The bench builds the block with a three-stage synchronizer, one more than the default. The added pin latency shows that edge detection, bit counting and output shifting stay aligned, since the host clocks at a slow fraction of the system clock. It keeps the output idle level at 0 and straps the device address to 1. With that strap the no-operation word, whose address field is 0, arrives as a foreign frame, so one vector walk covers both the foreign-frame path and carrying out pending data through a no-op.

// File: rtl/chan_spi_pkg.sv
package chan_spi_pkg;

   localparam int FRAME_W  = 24;
   localparam int DATA_W   = 16;
   localparam int SEL_W    = 5;
   localparam int DEV_W    = 2;
   localparam int CH_NUM   = 4;
   localparam int CH_W     = $clog2(CH_NUM);
   localparam int CH_KINDS = 6;
   localparam int GLB_NUM  = 2;
   localparam int SLOT_NUM = CH_KINDS * CH_NUM + GLB_NUM;
   localparam int SLOT_W   = $clog2(SLOT_NUM);

   // register kind, taken from the upper selector bits
   typedef enum logic [2:0] {
      K_CODE   = 3'd0,
      K_CTRL   = 3'd1,
      K_GAIN   = 3'd2,
      K_OFFS   = 3'd3,
      K_CLR    = 3'd4,
      K_SLEW   = 3'd5,
      K_GLOBAL = 3'd6,
      K_VOID   = 3'd7
   } kind_e;

   localparam logic [SEL_W-1:0] SEL_STATUS = 5'd24;
   localparam logic [SEL_W-1:0] SEL_MAIN   = 5'd25;
   localparam logic [SEL_W-1:0] SEL_DCDC   = 5'd26;

   // live bits of a slew-control word: enable, rate code, step code
   localparam logic [DATA_W-1:0] SLEW_KEEP = 16'h1FF8;

   typedef struct packed {
      logic              rd;
      logic [DEV_W-1:0]  dev;
      logic [SEL_W-1:0]  sel;
      logic [DATA_W-1:0] data;
   } frame_t;

   typedef struct packed {
      logic              hit;
      logic [SLOT_W-1:0] slot;
   } slot_map_t;

   // selector -> storage slot; channel kinds map one to one onto slots
   function automatic slot_map_t map_sel(input logic [SEL_W-1:0] sel);
      slot_map_t m;
      kind_e     k;
      k      = kind_e'(sel[SEL_W-1:CH_W]);
      m.hit  = 1'b0;
      m.slot = '0;
      if (k <= K_SLEW) begin
         m.hit  = 1'b1;
         m.slot = SLOT_W'(sel);
      end else if (sel == SEL_MAIN) begin
         m.hit  = 1'b1;
         m.slot = SLOT_W'(CH_KINDS * CH_NUM);
      end else if (sel == SEL_DCDC) begin
         m.hit  = 1'b1;
         m.slot = SLOT_W'(CH_KINDS * CH_NUM + 1);
      end
      return m;
   endfunction

   function automatic bit slot_is_slew(input int s);
      return (s < CH_KINDS * CH_NUM) && ((s / CH_NUM) == int'(K_SLEW));
   endfunction

endpackage

// File: rtl/chan_spi_port.sv
module chan_spi_port
   import chan_spi_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic SDO_IDLE    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               spi_csn,
   input  logic               spi_sclk,
   input  logic               spi_mosi,
   output logic               spi_sdo,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               frame_commit,
   output logic [FRAME_W-1:0] frame_word
);

   localparam int               CNT_W    = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("chan_spi_port: SYNC_STAGES must lie in 0..4");
   end

   logic [2:0] pin_raw;
   logic [2:0] pin_s;
   assign pin_raw = {spi_csn, spi_sclk, spi_mosi};

   if (SYNC_STAGES == 0) begin : g_direct
      assign pin_s = pin_raw;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0][2:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg <= {SYNC_STAGES{3'b100}};
         end else begin
            stg[0] <= pin_raw;
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign pin_s = stg[SYNC_STAGES-1];
   end

   logic csn_s, sclk_s, mosi_s;
   assign csn_s  = pin_s[2];
   assign sclk_s = pin_s[1];
   assign mosi_s = pin_s[0];

   logic csn_q, sclk_q;
   logic sclk_rise, sclk_fall, cs_fall, cs_rise;
   assign sclk_rise = sclk_s & ~sclk_q;
   assign sclk_fall = ~sclk_s & sclk_q;
   assign cs_fall   = ~csn_s & csn_q;
   assign cs_rise   = csn_s & ~csn_q;

   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] rx_sr;
   logic [FRAME_W-1:0] tx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csn_q   <= 1'b1;
         sclk_q  <= 1'b0;
         bit_cnt <= '0;
         rx_sr   <= '0;
         tx_sr   <= '0;
      end else begin
         csn_q  <= csn_s;
         sclk_q <= sclk_s;
         if (cs_fall) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= tx_word;
         end else if (!csn_s) begin
            if (sclk_rise) begin
               rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
               if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (sclk_fall) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_commit <= 1'b0;
         frame_word   <= '0;
      end else begin
         frame_commit <= cs_rise && (bit_cnt == CNT_FULL);
         if (cs_rise) frame_word <= rx_sr;
      end
   end

   assign spi_sdo = csn_s ? SDO_IDLE : tx_sr[FRAME_W-1];

   // R2: the edge counter saturates one past a full frame
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_SAT);

   // R9: output shifter only moves on a frame start or a falling serial edge
   p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_fall && !(sclk_fall && !csn_s)) |=> $stable(tx_sr));

endmodule

// File: rtl/chan_spi_decode.sv
module chan_spi_decode
   import chan_spi_pkg::*;
(
   input  logic              frame_commit,
   input  frame_t            frame_f,
   input  logic [DEV_W-1:0]  dev_addr,
   output logic              wr_en,
   output logic [SLOT_W-1:0] wr_slot,
   output logic [DATA_W-1:0] wr_data,
   output logic              arm_rd
);

   slot_map_t wmap;
   logic      addr_ok;

   always_comb begin
      wmap    = map_sel(frame_f.sel);
      addr_ok = (frame_f.dev == dev_addr);
      wr_en   = frame_commit && addr_ok && !frame_f.rd && wmap.hit;
      wr_slot = wmap.slot;
      wr_data = frame_f.data;
      arm_rd  = frame_commit && addr_ok && frame_f.rd;
   end

endmodule

// File: rtl/chan_spi_bank.sv
module chan_spi_bank
   import chan_spi_pkg::*;
(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [SLOT_W-1:0]                wr_slot,
   input  logic [DATA_W-1:0]                wr_data,
   output logic [SLOT_NUM-1:0][DATA_W-1:0]  slot_q
);

   logic [SLOT_NUM-1:0]             wr_stb;
   logic [SLOT_NUM-1:0][DATA_W-1:0] keep;

   for (genvar s = 0; s < SLOT_NUM; s++) begin : g_slot
      localparam logic [DATA_W-1:0] KEEP =
         slot_is_slew(s) ? SLEW_KEEP : {DATA_W{1'b1}};
      assign wr_stb[s] = wr_en && (wr_slot == SLOT_W'(s));
      assign keep[s]   = KEEP;
      if (slot_is_slew(s)) begin : g_rsv
         // R7: reserved slew bits never hold a one
         p_slew_rsv_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_q[s] & ~SLEW_KEEP) == '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else begin
         for (int s = 0; s < SLOT_NUM; s++) begin
            if (wr_stb[s]) slot_q[s] <= wr_data & keep[s];
         end
      end
   end

   // R3: a frame writes at most one register
   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb));

endmodule

// File: rtl/chan_spi_rdmux.sv
module chan_spi_rdmux
   import chan_spi_pkg::*;
(
   input  logic [SLOT_NUM-1:0][DATA_W-1:0] slot_q,
   input  logic [DATA_W-1:0]               status_word,
   input  logic [SEL_W-1:0]                rd_sel,
   output logic [DATA_W-1:0]               rd_data
);

   slot_map_t rmap;

   always_comb begin
      rmap = map_sel(rd_sel);
      if (rd_sel == SEL_STATUS) rd_data = status_word;
      else if (rmap.hit)        rd_data = slot_q[rmap.slot];
      else                      rd_data = '0;
   end

endmodule

// File: rtl/chan_spi_regfile.sv
module chan_spi_regfile
   import chan_spi_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic SDO_IDLE    = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spi_csn,
   input  logic                       spi_sclk,
   input  logic                       spi_mosi,
   output logic                       spi_sdo,
   input  logic [DEV_W-1:0]           dev_addr,
   input  logic [DATA_W-1:0]          status_word,
   output logic [CH_NUM*DATA_W-1:0]   ch_code,
   output logic [CH_NUM*DATA_W-1:0]   ch_ctrl,
   output logic [CH_NUM*DATA_W-1:0]   ch_gain,
   output logic [CH_NUM*DATA_W-1:0]   ch_offset,
   output logic [CH_NUM*DATA_W-1:0]   ch_clear,
   output logic [CH_NUM*DATA_W-1:0]   ch_slew,
   output logic [DATA_W-1:0]          main_ctrl,
   output logic [DATA_W-1:0]          dcdc_ctrl
);

   if ($bits(frame_t) != FRAME_W) begin : g_bad_frame
      $error("chan_spi_regfile: frame fields do not fill the frame");
   end
   if (CH_NUM != (1 << CH_W)) begin : g_bad_ch
      $error("chan_spi_regfile: channel count must be a power of two");
   end

   logic                            frame_commit;
   logic [FRAME_W-1:0]              frame_word;
   frame_t                          frame_f;
   logic [FRAME_W-1:0]              tx_word;
   logic                            wr_en;
   logic [SLOT_W-1:0]               wr_slot;
   logic [DATA_W-1:0]               wr_data;
   logic                            arm_rd;
   logic [SLOT_NUM-1:0][DATA_W-1:0] slot_q;
   logic [DATA_W-1:0]               rd_data;
   logic                            rd_armed;
   logic [SEL_W-1:0]                rd_sel;

   assign frame_f = frame_t'(frame_word);

   chan_spi_port #(
      .SYNC_STAGES (SYNC_STAGES),
      .SDO_IDLE    (SDO_IDLE)
   ) u_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .spi_csn      (spi_csn),
      .spi_sclk     (spi_sclk),
      .spi_mosi     (spi_mosi),
      .spi_sdo      (spi_sdo),
      .tx_word      (tx_word),
      .frame_commit (frame_commit),
      .frame_word   (frame_word)
   );

   chan_spi_decode u_decode (
      .frame_commit (frame_commit),
      .frame_f      (frame_f),
      .dev_addr     (dev_addr),
      .wr_en        (wr_en),
      .wr_slot      (wr_slot),
      .wr_data      (wr_data),
      .arm_rd       (arm_rd)
   );

   chan_spi_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_slot (wr_slot),
      .wr_data (wr_data),
      .slot_q  (slot_q)
   );

   chan_spi_rdmux u_rdmux (
      .slot_q      (slot_q),
      .status_word (status_word),
      .rd_sel      (rd_sel),
      .rd_data     (rd_data)
   );

   // pending readback pointer: set by a matching read, consumed by any frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_armed <= 1'b0;
         rd_sel   <= '0;
      end else if (frame_commit) begin
         rd_armed <= arm_rd;
         if (arm_rd) rd_sel <= frame_f.sel;
      end
   end

   assign tx_word = rd_armed ? {{(FRAME_W-DATA_W){1'b0}}, rd_data} : '0;

   for (genvar c = 0; c < CH_NUM; c++) begin : g_out
      assign ch_code  [c*DATA_W +: DATA_W] = slot_q[int'(K_CODE)*CH_NUM + c];
      assign ch_ctrl  [c*DATA_W +: DATA_W] = slot_q[int'(K_CTRL)*CH_NUM + c];
      assign ch_gain  [c*DATA_W +: DATA_W] = slot_q[int'(K_GAIN)*CH_NUM + c];
      assign ch_offset[c*DATA_W +: DATA_W] = slot_q[int'(K_OFFS)*CH_NUM + c];
      assign ch_clear [c*DATA_W +: DATA_W] = slot_q[int'(K_CLR)*CH_NUM + c];
      assign ch_slew  [c*DATA_W +: DATA_W] = slot_q[int'(K_SLEW)*CH_NUM + c];
   end
   assign main_ctrl = slot_q[CH_KINDS*CH_NUM];
   assign dcdc_ctrl = slot_q[CH_KINDS*CH_NUM + 1];

   // R3: register contents move only in the cycle after a committed frame
   p_write_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(slot_q) |-> $past(frame_commit));

   // R4: pending readback holds between committed frames
   p_pending_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_commit |=> ($stable(rd_armed) && $stable(rd_sel)));

   // R5: a committed non-read frame leaves nothing armed
   p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_commit && !frame_f.rd) |=> !rd_armed);

   // R6: a frame for another device touches no register and arms nothing
   p_foreign_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_commit && (frame_f.dev != dev_addr)) |=> ($stable(slot_q) && !rd_armed));

endmodule

// File: tb/test_chan_spi_regfile.sv
module test_chan_spi_regfile;

   localparam int HALF = 8;   // system clocks per serial half period
   localparam int NV   = 26;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        spi_csn, spi_sclk, spi_mosi;
   logic        spi_sdo;
   logic [1:0]  dev_addr    = 2'b01;
   logic [15:0] status_word = 16'h3C5A;
   logic [63:0] ch_code, ch_ctrl, ch_gain, ch_offset, ch_clear, ch_slew;
   logic [15:0] main_ctrl, dcdc_ctrl;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   chan_spi_regfile #(.SYNC_STAGES(3), .SDO_IDLE(1'b0)) i_chan_spi_regfile (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_csn     (spi_csn),
      .spi_sclk    (spi_sclk),
      .spi_mosi    (spi_mosi),
      .spi_sdo     (spi_sdo),
      .dev_addr    (dev_addr),
      .status_word (status_word),
      .ch_code     (ch_code),
      .ch_ctrl     (ch_ctrl),
      .ch_gain     (ch_gain),
      .ch_offset   (ch_offset),
      .ch_clear    (ch_clear),
      .ch_slew     (ch_slew),
      .main_ctrl   (main_ctrl),
      .dcdc_ctrl   (dcdc_ctrl)
   );

   // {frame sent, 24 bits expected back}; strap = 1, so 0x1CE000 is foreign
   localparam logic [47:0] VEC [NV] = '{
      {24'h201234, 24'h000000},  //  0 R8 first frame after reset: zeros; R3 code A
      {24'h28ABCD, 24'h000000},  //  1 R3 gain A
      {24'hA80000, 24'h000000},  //  2 R4 arm gain A
      {24'hA0FFFF, 24'h00ABCD},  //  3 R1 payload ignored on read; R4 gain A out
      {24'h1CE000, 24'h001234},  //  4 R5 no-op carries pending code A
      {24'h1CE000, 24'h000000},  //  5 R5 nothing pending
      {24'h35FFFF, 24'h000000},  //  6 R7 slew B all ones
      {24'hB50000, 24'h000000},  //  7 arm slew B
      {24'h2F5A5A, 24'h001FF8},  //  8 R7 reserved bits dropped; offset D write
      {24'h390F0F, 24'h000000},  //  9 R3 main control
      {24'hB90000, 24'h000000},  // 10 arm main
      {24'hBA0000, 24'h000F0F},  // 11 main out, arm dc-to-dc
      {24'hBB0000, 24'h000000},  // 12 dc-to-dc reset value, arm 27
      {24'h38FFFF, 24'h000000},  // 13 R4 code 27 zero; R3 write to 24 ignored
      {24'hB80000, 24'h000000},  // 14 arm status
      {24'hAF0000, 24'h003C5A},  // 15 R4 status input out, arm offset D
      {24'h4F1111, 24'h005A5A},  // 16 R6 foreign write
      {24'hAF0000, 24'h000000},  // 17 R5 foreign frame disarmed
      {24'h8F0000, 24'h005A5A},  // 18 R6 foreign read, offset D unchanged
      {24'h1CE000, 24'h000000},  // 19 R6 foreign read armed nothing
      {24'h327777, 24'h000000},  // 20 R3 clear code C
      {24'hB20000, 24'h000000},  // 21 arm clear C
      {24'h2600C3, 24'h007777},  // 22 R5 write frame still carries data
      {24'hA60000, 24'h000000},  // 23 arm control C
      {24'h1CE000, 24'h0000C3},  // 24 R5 no-op carries control C
      {24'hBF0000, 24'h000000}   // 25 arm code 31
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic spi_xfer(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
      rx = '0;
      spi_csn = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = (i < 24) ? tx[23-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         rx = {rx[22:0], spi_sdo};
         spi_sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      spi_csn = 1'b1;
      repeat (3*HALF) @(negedge clk);
   endtask

   task automatic do_reset();
      spi_csn  = 1'b1;
      spi_sclk = 1'b0;
      spi_mosi = 1'b0;
      rst_n    = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [23:0] rx;
      do_reset();

      // R8 reset state at the ports
      check("R8 outputs after reset",
            ch_code | ch_ctrl | ch_gain | ch_offset | ch_clear | ch_slew
            | {48'h0, main_ctrl} | {48'h0, dcdc_ctrl}, 64'h0);
      check("R9 idle output level", {63'h0, spi_sdo}, 64'h0);

      for (int v = 0; v < NV; v++) begin
         spi_xfer(VEC[v][47:24], 24, rx);
         check($sformatf("R1/R4 vector %0d", v), {40'h0, rx}, {40'h0, VEC[v][23:0]});
      end

      // R10 lane placement on the output ports
      check("R10 code A lane",     {48'h0, ch_code[15:0]},    64'h1234);
      check("R10 gain A lane",     {48'h0, ch_gain[15:0]},    64'hABCD);
      check("R10 offset D lane",   {48'h0, ch_offset[63:48]}, 64'h5A5A);
      check("R10 clear C lane",    {48'h0, ch_clear[47:32]},  64'h7777);
      check("R10 control C lane",  {48'h0, ch_ctrl[47:32]},   64'h00C3);
      check("R7 slew B lane",      {48'h0, ch_slew[31:16]},   64'h1FF8);
      check("R10 main control",    {48'h0, main_ctrl},        64'h0F0F);
      check("R3 dc-to-dc untouched", {48'h0, dcdc_ctrl},      64'h0);

      // R2 short and long frames are dropped, pending read survives
      spi_xfer(24'hA80000, 24, rx);
      check("R4 code 31 reads zero", {40'h0, rx}, 64'h0);
      check("R9 output idle between frames", {63'h0, spi_sdo}, 64'h0);
      spi_xfer(24'h282222, 23, rx);
      spi_xfer(24'h283333, 25, rx);
      check("R2 gain A kept after bad lengths", {48'h0, ch_gain[15:0]}, 64'hABCD);
      spi_xfer(24'h1CE000, 24, rx);
      check("R2 pending read kept across bad lengths", {40'h0, rx}, 64'h00ABCD);

      // R8 reset mid-run clears registers and the pending read
      spi_xfer(24'hA00000, 24, rx);
      do_reset();
      check("R8 outputs after second reset",
            ch_code | ch_ctrl | ch_gain | ch_offset | ch_clear | ch_slew
            | {48'h0, main_ctrl}, 64'h0);
      spi_xfer(24'h1CE000, 24, rx);
      check("R8 pending read cleared", {40'h0, rx}, 64'h0);
      spi_xfer(24'hA00000, 24, rx);
      spi_xfer(24'h1CE000, 24, rx);
      check("R8 code A cleared", {40'h0, rx}, 64'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule